// File: doc/BRIEF.md
# Integer add/subtract unit with condition flags

This block is a purely combinational N-bit integer adder/subtractor. A 2-bit operation select picks one of four operations: plain add, add with an incoming carry, plain subtract, and subtract with an incoming carry. All four use one ripple adder. Subtraction reuses that adder by inverting the second operand and the carry-in. The result bits come out the same whether the operands are read as signed or unsigned. Only the flags say something about signedness: Negative, Zero, Carry and oVerflow.

A single configuration input, `borrow_mode_i`, sets how the carry flag behaves on subtract-type operations. With it low, a carry flag of 1 after a subtract means that no borrow happened, which is the carry-out of the adder unchanged. With it high, the carry flag is the inverted adder carry-out, so 1 means a borrow happened. In that mode the incoming flag of a subtract-with-carry is also inverted before it enters the adder. This keeps chained multiword subtraction correct in both modes. The block holds no state. Flag storage and condition evaluation belong to the surrounding datapath.

Top module: `addsub_flags`

## Requirements
- R1: With `op_i` = 2'b00 (add), `sum_o` is `a_i + b_i` modulo 2^WIDTH and `carry_o` is bit WIDTH of the full sum. For example, at WIDTH=4, 1010 + 1101 gives 0111 with carry 1.
- R2: With `op_i` = 2'b01 (add with carry), `cf_i` is the carry into bit 0. `{carry_o, sum_o}` equals `a_i + b_i + cf_i`.
- R3: With `op_i` = 2'b10 (subtract), `sum_o` is `a_i - b_i` modulo 2^WIDTH. It is formed as `a_i + ~b_i + 1`.
- R4: With `op_i` = 2'b11 (subtract with carry), `sum_o` is `a_i - b_i - borrow` modulo 2^WIDTH. The borrow is `~cf_i` when `borrow_mode_i` = 0 and `cf_i` when `borrow_mode_i` = 1.
- R5: On subtract-type operations (`op_i[1]` = 1), `carry_o` = 1 means "no borrow" (`a_i >= b_i + borrow`) when `borrow_mode_i` = 0, and means "borrow" when `borrow_mode_i` = 1.
- R6: On add-type operations (`op_i[1]` = 0), `borrow_mode_i` has no effect on any output. On plain add, `cf_i` has no effect on any output.
- R7: `ovf_o` is 1 exactly when the two's-complement result of the operation does not fit in WIDTH bits.
- R8: `neg_o` equals the most significant bit of `sum_o`.
- R9: `zero_o` is 1 exactly when every bit of `sum_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand (the subtrahend on subtract-type operations) |
| op_i | input | 2 | Operation select: 00 add, 01 add with carry, 10 subtract, 11 subtract with carry |
| cf_i | input | 1 | Incoming carry flag, used by the with-carry operations |
| borrow_mode_i | input | 1 | 0: carry flag on subtract means no borrow; 1: carry flag on subtract means borrow |
| sum_o | output | WIDTH | Result bits |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry or borrow flag |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
At WIDTH=4 the bench sweeps every operand pair under every operation, incoming-carry value and polarity setting. It compares the outputs against a model written with wide signed and unsigned integers. Directed vectors target the pairs that break designs in typical ways:
- Zero minus the most negative value and the most positive value plus one catch an overflow taken from the carry-out alone.
- 0 - 0 - 1 and a borrow-free 0 - 0 in both polarities catch a subtract-with-carry that forgets to invert the incoming flag, which would be off by one.
- Subtracts with equal operands or a zero minuend catch a carry flag whose polarity is reversed.
- Varying `borrow_mode_i` and `cf_i` on adds catches leakage where neither input should matter.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_SBC = 2'b11
    } addsub_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    input  logic             cf_i,
    input  logic             borrow_mode_i,
    output logic [WIDTH-1:0] b_eff_o,
    output logic             cin_o,
    output logic             is_sub_o
);
    import addsub_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] b_eff;
        logic             cin;
        logic             is_sub;
    } prep_t;

    prep_t prep_d;

    always_comb begin
        prep_d = '0;
        unique case (addsub_op_e'(op_i))
            OP_ADD: begin
                prep_d.b_eff  = b_i;
                prep_d.cin    = 1'b0;
                prep_d.is_sub = 1'b0;
            end
            OP_ADC: begin
                prep_d.b_eff  = b_i;
                prep_d.cin    = cf_i;
                prep_d.is_sub = 1'b0;
            end
            OP_SUB: begin
                prep_d.b_eff  = ~b_i;
                prep_d.cin    = 1'b1;
                prep_d.is_sub = 1'b1;
            end
            OP_SBC: begin
                prep_d.b_eff  = ~b_i;
                // In borrow polarity the incoming flag means "borrow", so the
                // adder wants its complement as the carry into bit 0.
                prep_d.cin    = borrow_mode_i ? ~cf_i : cf_i;
                prep_d.is_sub = 1'b1;
            end
            default: prep_d = '0;
        endcase
    end

    assign b_eff_o  = prep_d.b_eff;
    assign cin_o    = prep_d.cin;
    assign is_sub_o = prep_d.is_sub;

endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_msb_in_o,
    output logic             c_out_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] chain;

    assign chain[0] = cin_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic axb;
        assign axb          = a_i[i] ^ b_i[i];
        assign sum_o[i]     = axb ^ chain[i];
        assign chain[i + 1] = (a_i[i] & b_i[i]) | (axb & chain[i]);
    end

    assign c_msb_in_o = chain[MSB];
    assign c_out_o    = chain[WIDTH];

endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]     sum_i,
    input  logic                 c_msb_in_i,
    input  logic                 c_out_i,
    input  logic                 is_sub_i,
    input  logic                 borrow_mode_i,
    output addsub_pkg::nzcv_t    flags_o
);
    import addsub_pkg::*;

    localparam int MSB = WIDTH - 1;

    nzcv_t flags_d;

    always_comb begin
        flags_d.n = sum_i[MSB];
        flags_d.z = ~|sum_i;
        flags_d.c = (is_sub_i & borrow_mode_i) ? ~c_out_i : c_out_i;
        flags_d.v = c_msb_in_i ^ c_out_i;
    end

    assign flags_o = flags_d;

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    input  logic             cf_i,
    input  logic             borrow_mode_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             neg_o,
    output logic             zero_o,
    output logic             carry_o,
    output logic             ovf_o
);
    import addsub_pkg::*;

    logic [WIDTH-1:0] b_eff;
    logic             cin;
    logic             is_sub;
    logic [WIDTH-1:0] sum;
    logic             c_msb_in;
    logic             c_out;
    nzcv_t            flags;

    addsub_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .b_i           (b_i),
        .op_i          (op_i),
        .cf_i          (cf_i),
        .borrow_mode_i (borrow_mode_i),
        .b_eff_o       (b_eff),
        .cin_o         (cin),
        .is_sub_o      (is_sub)
    );

    addsub_ripple #(.WIDTH(WIDTH)) u_adder (
        .a_i        (a_i),
        .b_i        (b_eff),
        .cin_i      (cin),
        .sum_o      (sum),
        .c_msb_in_o (c_msb_in),
        .c_out_o    (c_out)
    );

    addsub_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .sum_i         (sum),
        .c_msb_in_i    (c_msb_in),
        .c_out_i       (c_out),
        .is_sub_i      (is_sub),
        .borrow_mode_i (borrow_mode_i),
        .flags_o       (flags)
    );

    assign sum_o   = sum;
    assign neg_o   = flags.n;
    assign zero_o  = flags.z;
    assign carry_o = flags.c;
    assign ovf_o   = flags.v;

endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [1:0]       op_i,
    input logic             cf_i,
    input logic             borrow_mode_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             neg_o,
    input logic             zero_o,
    input logic             carry_o,
    input logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide_add;
    logic [WIDTH:0] wide_adc;
    logic           same_sign;
    logic           diff_sign;
    logic           res_flip;

    always_comb begin
        wide_add  = {1'b0, a_i} + {1'b0, b_i};
        wide_adc  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cf_i};
        same_sign = (a_i[MSB] == b_i[MSB]);
        diff_sign = ~same_sign;
        res_flip  = (sum_o[MSB] != a_i[MSB]);

        if (op_i == 2'b00) begin
            a_r1_add_sum: assert ({carry_o, sum_o} == wide_add)
                else $error("R1 add result mismatch");
        end
        if (op_i == 2'b01) begin
            a_r2_adc_sum: assert ({carry_o, sum_o} == wide_adc)
                else $error("R2 add-with-carry result mismatch");
        end
        if (op_i == 2'b10) begin
            a_r3_sub_sum: assert (sum_o == WIDTH'(a_i - b_i))
                else $error("R3 subtract result mismatch");
            a_r5_sub_carry: assert (carry_o == (borrow_mode_i ? (a_i < b_i) : (a_i >= b_i)))
                else $error("R5 subtract carry polarity mismatch");
        end
        if (op_i[1] == 1'b0) begin
            a_r7_add_ovf: assert (ovf_o == (same_sign & res_flip))
                else $error("R7 add overflow mismatch");
        end else begin
            a_r7_sub_ovf: assert (ovf_o == (diff_sign & res_flip))
                else $error("R7 subtract overflow mismatch");
        end
        a_r8_neg: assert (neg_o == sum_o[MSB])
            else $error("R8 negative flag mismatch");
        a_r9_zero: assert (zero_o == (sum_o == '0))
            else $error("R9 zero flag mismatch");
    end

endmodule

bind addsub_flags addsub_flags_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i           (a_i),
    .b_i           (b_i),
    .op_i          (op_i),
    .cf_i          (cf_i),
    .borrow_mode_i (borrow_mode_i),
    .sum_o         (sum_o),
    .neg_o         (neg_o),
    .zero_o        (zero_o),
    .carry_o       (carry_o),
    .ovf_o         (ovf_o)
);

// File: tb/tb_addsub_flags.sv
`timescale 1ns/1ps
module tb_addsub_flags;
    localparam int W = 4;
    localparam int NVEC = 13;

    // vector fields: op(2) cf bm a(4) b(4) sum(4) n z c v
    localparam logic [19:0] VECS [NVEC] = '{
        20'b00_0_0_1010_1101_0111_0011,
        20'b00_0_0_0111_0001_1000_1001,
        20'b00_1_0_1110_0001_1111_1000,
        20'b01_1_0_1111_0000_0000_0110,
        20'b10_0_0_1100_1100_0000_0110,
        20'b10_0_0_0000_0110_1010_1000,
        20'b10_0_1_0000_0110_1010_1010,
        20'b10_0_0_0000_1000_1000_1001,
        20'b11_0_0_0101_0010_0010_0010,
        20'b11_1_1_0101_0010_0010_0000,
        20'b11_0_1_0000_0000_0000_0100,
        20'b11_0_0_0000_0000_1111_1000,
        20'b11_1_1_1000_0000_0111_0001
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b, sum;
    logic [1:0]   op;
    logic         cf, bm, n, z, c, v;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    addsub_flags #(.WIDTH(W)) dut (
        .a_i(a), .b_i(b), .op_i(op), .cf_i(cf), .borrow_mode_i(bm),
        .sum_o(sum), .neg_o(n), .zero_o(z), .carry_o(c), .ovf_o(v)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s op=%0d cf=%0d bm=%0d a=%0d b=%0d actual=%0d expected=%0d",
                     tag, op, cf, bm, a, b, got, exp);
        end
    endtask

    task automatic apply(input logic [1:0] o, input logic f, input logic m,
                         input logic [W-1:0] x, input logic [W-1:0] y);
        @(negedge clk);
        op = o; cf = f; bm = m; a = x; b = y;
        #1;
    endtask

    initial begin
        a = '0; b = '0; op = 2'b00; cf = 1'b0; bm = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // reset-time idle inputs: 0 + 0
        check("R9 idle zero flag", z, 1);
        check("R1 idle sum", sum, 0);
        check("R5 idle carry", c, 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [19:0] e;
            e = VECS[i];
            apply(e[19:18], e[17], e[16], e[15:12], e[11:8]);
            check(e[19] ? (e[18] ? "R4 vector sum" : "R3 vector sum")
                        : (e[18] ? "R2 vector sum" : "R1 vector sum"), sum, e[7:4]);
            check("R8 vector N", n, e[3]);
            check("R9 vector Z", z, e[2]);
            check("R5 vector C", c, e[1]);
            check("R7 vector V", v, e[0]);
        end

        // R6: polarity and cf_i have no effect on add-type outputs
        apply(2'b00, 1'b0, 1'b0, 4'b1001, 4'b1000);
        begin
            logic [7:0] ref0;
            ref0 = {sum, n, z, c, v};
            apply(2'b00, 1'b1, 1'b1, 4'b1001, 4'b1000);
            check("R6 add ignores cf_i and borrow_mode_i", {sum, n, z, c, v}, ref0);
            apply(2'b01, 1'b1, 1'b0, 4'b0111, 4'b1000);
            ref0 = {sum, n, z, c, v};
            apply(2'b01, 1'b1, 1'b1, 4'b0111, 4'b1000);
            check("R6 adc ignores borrow_mode_i", {sum, n, z, c, v}, ref0);
        end

        // exhaustive sweep against wide-integer model
        for (int o = 0; o < 4; o++)
        for (int f = 0; f < 2; f++)
        for (int m = 0; m < 2; m++)
        for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) begin
            int r, sx, sy, sr, brw, es, ec, ev;
            apply(2'(o), f[0], m[0], 4'(x), 4'(y));
            sx = (x >= 8) ? x - 16 : x;
            sy = (y >= 8) ? y - 16 : y;
            if (o < 2) begin
                brw = (o == 1) ? f : 0;
                r  = x + y + brw;
                sr = sx + sy + brw;
                ec = (r > 15) ? 1 : 0;
            end else begin
                brw = (o == 2) ? 0 : (m ? f : 1 - f);
                r  = x - y - brw;
                sr = sx - sy - brw;
                ec = (r >= 0) ? 1 : 0;
                if (m == 1) ec = 1 - ec;
            end
            es = r & 15;
            ev = (sr > 7 || sr < -8) ? 1 : 0;
            check(o == 0 ? "R1 sweep sum" : o == 1 ? "R2 sweep sum" :
                  o == 2 ? "R3 sweep sum" : "R4 sweep sum", sum, es);
            check("R5 sweep carry", c, ec);
            check("R7 sweep overflow", v, ev);
            check("R8 sweep negative", n, (es >> 3) & 1);
            check("R9 sweep zero", z, (es == 0) ? 1 : 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule